// File: doc/BRIEF.md
# Global History Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps one shared shift register of recent branch outcomes and a table of 2-bit saturating counters. A fetch address is folded into that history by XOR to choose one counter, and the counter's upper bit gives the prediction in the same cycle. Branches that share a history pattern but sit at different addresses therefore usually train different counters.

The front end presents a fetch address on the lookup port. The block returns the predicted direction together with the history value that was used. When a lookup is marked valid, the predicted direction is shifted into the history at once, so back-to-back branches see each other's guesses. When a branch resolves, the back end sends its address, its real outcome and the history snapshot from its lookup. The counter chosen by that snapshot is trained. If the branch was mispredicted, the history is rebuilt from the snapshot with the real outcome appended.

Top module: `gpred_top`

## Requirements
- R1: After reset, every counter holds 01 (weakly not-taken) and the history register is all zeros. Every lookup then predicts not-taken and `lk_hist` reads 0.
- R2: `lk_taken` is 1 when the selected counter is 10 or 11 and 0 when it is 00 or 01. It is valid combinationally in the same cycle as `lk_pc`.
- R3: An update with `up_taken`=1 adds one to the selected counter and saturates at 11.
- R4: An update with `up_taken`=0 subtracts one from the selected counter and saturates at 00. A single opposite outcome from a strong state (00 or 11) does not change the prediction.
- R5: The counter index is `hist XOR pc[HIST_W+1:2]`. PC bits [1:0] and the PC bits above HIST_W+1 have no effect on which counter is selected.
- R6: A cycle with `lk_valid`=1 and no repair shifts the history left by one bit, with the predicted direction (1 = taken) entering bit 0. `lk_hist` shows the history as it was before that shift.
- R7: An update with `up_valid`=1 and `up_mispred`=1 sets the history to `{up_hist[HIST_W-2:0], up_taken}` on the next edge. This repair wins over a speculative shift in the same cycle.
- R8: An update with `up_mispred`=0 trains the counter but leaves the history register unchanged.
- R9: When a lookup and an update select the same counter in one cycle, the lookup returns the prediction from the counter value before the update.
- R10: With `lk_valid`=0 and no repair, the history register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup is real; shift the prediction into the history |
| lk_pc | input | PC_W | Fetch address being predicted |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_hist | output | HIST_W | History used for this lookup (snapshot to return with the update) |
| up_valid | input | 1 | A resolved branch is presented |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_mispred | input | 1 | The earlier prediction was wrong; repair the history |
| up_hist | input | HIST_W | History snapshot returned from the lookup |

## Verification
A wrong counter shows up as a wrong `lk_taken` the first time a lookup reaches that entry. This can be cycles or many updates later, so the bench keeps a full shadow table and compares every lookup against it. A wrong history is visible right away on `lk_hist` in the next cycle, and it also moves later lookups to the wrong counters. Directed sequences cover saturation at both ends, hysteresis, ignored PC bits, same-entry collisions and repair priority. Random traffic covers the interaction of speculation and repair.

// File: rtl/gpred_pkg.sv
// Shared types and helpers for the global history direction predictor.
// Assumes the history width is at least 2 bits.
package gpred_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_SNT = 2'b00;
    localparam ctr_t CTR_WNT = 2'b01;
    localparam ctr_t CTR_WT  = 2'b10;
    localparam ctr_t CTR_ST  = 2'b11;

    // Saturating step of a 2-bit counter toward the observed outcome.
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        if (taken)
            return (cur == CTR_ST) ? CTR_ST : ctr_t'(cur + 2'd1);
        else
            return (cur == CTR_SNT) ? CTR_SNT : ctr_t'(cur - 2'd1);
    endfunction

endpackage

// File: rtl/gpred_hist.sv
// Global outcome history register.
// A valid lookup shifts in its predicted bit. A repair replaces the history
// with a snapshot and the true outcome, and wins over a lookup in the same cycle.
module gpred_hist #(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spec_en,
    input  logic              spec_bit,
    input  logic              rep_en,
    input  logic [HIST_W-1:0] rep_hist,
    input  logic              rep_bit,
    output logic [HIST_W-1:0] hist
);

    // Hold, speculate or repair the shared history.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist <= '0;
        else if (rep_en)
            hist <= {rep_hist[HIST_W-2:0], rep_bit};
        else if (spec_en)
            hist <= {hist[HIST_W-2:0], spec_bit};
    end

    AST_REPAIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rep_en |=> hist == {$past(rep_hist[HIST_W-2:0]), $past(rep_bit)}); // R7

    AST_SPEC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_en && !rep_en) |=> hist == {$past(hist[HIST_W-2:0]), $past(spec_bit)}); // R6

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!spec_en && !rep_en) |=> $stable(hist)); // R10

endmodule

// File: rtl/gpred_table.sv
// Table of 2-bit saturating counters with one combinational read port and one
// synchronous training port. A read of the entry being trained in the same
// cycle sees the old value.
module gpred_table
    import gpred_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    localparam int DEPTH = 1 << IDX_W;

    ctr_t cnt [DEPTH];
    ctr_t wr_cur;

    // Read the selected counters for prediction and training.
    always_comb begin
        rd_ctr = cnt[rd_idx];
        wr_cur = cnt[wr_idx];
    end

    // Reset all counters to weakly not-taken, then train one per update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                cnt[i] <= CTR_WNT;
        end else if (wr_en) begin
            cnt[wr_idx] <= ctr_step(wr_cur, wr_taken);
        end
    end

    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && wr_cur == CTR_ST) |=> cnt[$past(wr_idx)] == CTR_ST); // R3

    AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && wr_cur == CTR_SNT) |=> cnt[$past(wr_idx)] == CTR_SNT); // R4

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && wr_cur != CTR_ST)
            |=> cnt[$past(wr_idx)] == ctr_t'($past(wr_cur) + 2'd1)); // R3

endmodule

// File: rtl/gpred_top.sv
// Global history direction predictor.
// The lookup index is the history XOR PC bits [HIST_W+1:2]. The update index
// uses the returned snapshot, so training reaches the counter that was read.
// Assumes PC_W > HIST_W + 2 and HIST_W >= 2.
module gpred_top
    import gpred_pkg::*;
#(
    parameter int HIST_W = 8,
    parameter int PC_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              lk_taken,
    output logic [HIST_W-1:0] lk_hist,
    input  logic              up_valid,
    input  logic [PC_W-1:0]   up_pc,
    input  logic              up_taken,
    input  logic              up_mispred,
    input  logic [HIST_W-1:0] up_hist
);

    logic [HIST_W-1:0] hist;
    logic [HIST_W-1:0] lk_idx;
    logic [HIST_W-1:0] up_idx;
    ctr_t              lk_ctr;
    logic              unused_pc_bits;

    // Form both table indices by folding history with word-address bits.
    always_comb begin
        lk_idx   = hist    ^ lk_pc[HIST_W+1:2];
        up_idx   = up_hist ^ up_pc[HIST_W+1:2];
        lk_taken = lk_ctr[1];
        lk_hist  = hist;
    end

    // Collect PC bits that deliberately take no part in indexing.
    assign unused_pc_bits = ^{lk_pc[PC_W-1:HIST_W+2], lk_pc[1:0],
                              up_pc[PC_W-1:HIST_W+2], up_pc[1:0]};

    gpred_hist #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .spec_en  (lk_valid),
        .spec_bit (lk_taken),
        .rep_en   (up_valid && up_mispred),
        .rep_hist (up_hist),
        .rep_bit  (up_taken),
        .hist     (hist)
    );

    gpred_table #(.IDX_W(HIST_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_ctr   (lk_ctr),
        .wr_en    (up_valid),
        .wr_idx   (up_idx),
        .wr_taken (up_taken)
    );

    AST_NO_REPAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_mispred && !lk_valid) |=> $stable(lk_hist)); // R8

endmodule

// File: tb/test_gpred_top.sv
// Self-checking bench for gpred_top. It keeps a shadow model built from the
// requirements, runs directed corner cases and then seeded random traffic.
module test_gpred_top;

    localparam int HW    = 8;
    localparam int PW    = 32;
    localparam int DEPTH = 1 << HW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [PW-1:0] lk_pc = '0;
    logic          lk_taken;
    logic [HW-1:0] lk_hist;
    logic          up_valid = 1'b0;
    logic [PW-1:0] up_pc = '0;
    logic          up_taken = 1'b0;
    logic          up_mispred = 1'b0;
    logic [HW-1:0] up_hist = '0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [1:0]    m_ctr [DEPTH];
    logic [HW-1:0] m_hist;

    gpred_top #(.HIST_W(HW), .PC_W(PW)) i_gpred_top (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_hist(lk_hist),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
        .up_mispred(up_mispred), .up_hist(up_hist)
    );

    always #10 clk = ~clk;

    function automatic logic [HW-1:0] m_idx(input logic [HW-1:0] h, input logic [PW-1:0] pc);
        return h ^ pc[HW+1:2];
    endfunction

    function automatic logic [1:0] m_step(input logic [1:0] c, input logic t);
        if (t) return (c == 2'b11) ? 2'b11 : c + 2'd1;
        return (c == 2'b00) ? 2'b00 : c - 2'd1;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("[TB] FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One cycle: drive, check lookup outputs against the model, advance the model.
    task automatic cyc(input string tag, input logic lv, input logic [PW-1:0] lpc,
                       input logic uv, input logic [PW-1:0] upc, input logic ut,
                       input logic um, input logic [HW-1:0] uh);
        logic          exp_pred;
        logic [HW-1:0] nh;
        @(negedge clk);
        lk_valid = lv; lk_pc = lpc; up_valid = uv; up_pc = upc;
        up_taken = ut; up_mispred = um; up_hist = uh;
        #2;
        exp_pred = m_ctr[m_idx(m_hist, lpc)][1];
        check(tag, "lk_taken", int'(lk_taken), int'(exp_pred));
        check(tag, "lk_hist", int'(lk_hist), int'(m_hist));
        nh = m_hist;
        if (uv && um) nh = {uh[HW-2:0], ut};
        else if (lv)  nh = {m_hist[HW-2:0], exp_pred};
        @(posedge clk);
        if (uv) m_ctr[m_idx(uh, upc)] = m_step(m_ctr[m_idx(uh, upc)], ut);
        m_hist = nh;
    endtask

    task automatic idle();
        @(negedge clk);
        lk_valid = 0; up_valid = 0; up_mispred = 0;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_run++; n_fail++;
            $display("[TB] FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [PW-1:0] pa;
        for (int i = 0; i < DEPTH; i++) m_ctr[i] = 2'b01;
        m_hist = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: every entry weakly not-taken, history zero
        for (int i = 0; i < 8; i++)
            cyc("R1", 1'b0, PW'(i * 4 * 37), 1'b0, '0, 1'b0, 1'b0, '0);

        // R3: train one entry (history 0) up past saturation
        pa = 32'h0000_0040;
        cyc("R3", 1'b0, pa, 1'b1, pa, 1'b1, 1'b0, '0);
        cyc("R2", 1'b0, pa, 1'b1, pa, 1'b1, 1'b0, '0);
        cyc("R3", 1'b0, pa, 1'b1, pa, 1'b1, 1'b0, '0);
        cyc("R3", 1'b0, pa, 1'b0, '0, 1'b0, 1'b0, '0);
        // R4: one not-taken from strong taken keeps taken
        cyc("R4", 1'b0, pa, 1'b1, pa, 1'b0, 1'b0, '0);
        cyc("R4", 1'b0, pa, 1'b0, '0, 1'b0, 1'b0, '0);
        for (int i = 0; i < 4; i++)
            cyc("R4", 1'b0, pa, 1'b1, pa, 1'b0, 1'b0, '0);
        // R4: saturated at 00, one taken keeps not-taken
        cyc("R4", 1'b0, pa, 1'b1, pa, 1'b1, 1'b0, '0);
        cyc("R4", 1'b0, pa, 1'b0, '0, 1'b0, 1'b0, '0);

        // R5: train a new entry to taken, then vary ignored PC bits
        pa = 32'h0000_0100;
        for (int i = 0; i < 2; i++)
            cyc("R5", 1'b0, pa, 1'b1, pa, 1'b1, 1'b0, '0);
        cyc("R5", 1'b0, pa | 32'h3, 1'b0, '0, 1'b0, 1'b0, '0);
        cyc("R5", 1'b0, pa | 32'hFF00_0000, 1'b0, '0, 1'b0, 1'b0, '0);
        cyc("R5", 1'b0, pa ^ 32'h4, 1'b0, '0, 1'b0, 1'b0, '0);

        // R9: collision on a weakly not-taken entry, lookup sees old value
        pa = 32'h0000_0200;
        cyc("R9", 1'b0, pa, 1'b1, pa, 1'b1, 1'b0, '0);
        cyc("R9", 1'b0, pa, 1'b0, '0, 1'b0, 1'b0, '0);

        // R6: speculative shifts with taken and not-taken predictions
        cyc("R6", 1'b1, 32'h0000_0100, 1'b0, '0, 1'b0, 1'b0, '0);
        cyc("R6", 1'b1, 32'h0000_0800, 1'b0, '0, 1'b0, 1'b0, '0);
        cyc("R10", 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, '0);
        cyc("R10", 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, '0);
        // R8: correct-prediction update leaves history
        cyc("R8", 1'b0, '0, 1'b1, 32'h10, 1'b1, 1'b0, 8'hA5);
        cyc("R8", 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, '0);
        // R7: repair together with a lookup, repair wins
        cyc("R7", 1'b1, 32'h0000_0100, 1'b1, 32'h20, 1'b1, 1'b1, 8'h5A);
        cyc("R7", 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, '0);
        cyc("R7", 1'b0, '0, 1'b1, 32'h24, 1'b0, 1'b1, 8'hFF);
        cyc("R7", 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, '0);

        // Random traffic: R2 R5 R6 R7 R8 R9 against the shadow model
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            logic [PW-1:0] rp;
            logic [PW-1:0] wp;
            logic [HW-1:0] wh;
            rp = $urandom() & 32'h0000_0FFF;
            wp = ($urandom() % 4 == 0) ? rp : ($urandom() & 32'h0000_0FFF);
            wh = ($urandom() % 3 == 0) ? m_hist : HW'($urandom());
            cyc("R2", 1'($urandom() % 2), rp, 1'($urandom() % 4 != 0), wp,
                1'($urandom() % 2), 1'($urandom() % 5 == 0), wh);
        end
        idle();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule